// File: doc/BRIEF.md
# SMBus Descriptor Ring Controller

This block sits in front of a descriptor-driven SMBus master. Software programs a 64-bit ring base address and a ring length. It then advances a head index in the control register and sets the run bit. The controller keeps its own tail index. Whenever the two indices differ and the run bit is set, it asks a downstream sequencer to fetch and execute the descriptor at the tail. It holds that request until the sequencer signals that the descriptor is finished, and then moves the tail forward by one slot, wrapping at the end of the ring.

Each finished descriptor reports two things: whether it succeeded, and whether it asked for an interrupt. From these the controller sets a completion flag and an error flag in its status register. Software clears either flag by writing a one to it. The interrupt line is high while either flag is set. The register port is a simple 32-bit write strobe with a combinational read path, addressed by byte offset.

Top module: `smb_ring_ctrl`

## Requirements
- R1: After reset, the control word reads 0, the status word reads 0, both base words read 0, the ring-length register reads 31 (32 slots), and `fetch_req` and `irq` are low.
- R2: The base address is 64 bits wide. Its low word is at offset 0x00 and its high word at 0x04. `fetch_addr` equals base + 16 × tail.
- R3: A fetch is issued when the run bit is set and the tail differs from the head. `fetch_req` then stays high until `seq_done`, and status bit 0 (in progress) is 1 while it is high.
- R4: Each `seq_done` during a fetch advances the tail by one slot. The tail appears in status bits 23:16.
- R5: No fetch is issued while tail equals head or while the run bit (control bit 0) is clear. Clearing the run bit during a fetch lets that descriptor finish, and no further descriptor is started.
- R6: Status bit 5 (completion) is set when a finished descriptor reports `seq_irq` high; otherwise it is left alone.
- R7: Status bit 4 (error) is set when a finished descriptor reports `seq_ok` low while control bit 4 (error enable) is 1. It is not set while control bit 4 is 0.
- R8: Writing status (offset 0x0C) clears each of bits 4 and 5 that is written as 1 and keeps each bit written as 0. A new event in the same cycle wins over the clear.
- R9: `irq` is high exactly when status bit 4 or bit 5 is set.
- R10: `seq_done` while no fetch is outstanding changes neither the tail nor the status flags.
- R11: The ring-length register (offset 0x10, low 8 bits) holds the number of slots minus one. After the slot numbered by that value, the tail wraps to slot 0. The head sits in control bits 23:16 at offset 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| fetch_req | output | 1 | Descriptor fetch outstanding |
| fetch_addr | output | 64 | Address of the descriptor being fetched |
| seq_done | input | 1 | Sequencer finished the current descriptor |
| seq_ok | input | 1 | Finished descriptor succeeded |
| seq_irq | input | 1 | Finished descriptor requested a completion interrupt |
| irq | output | 1 | Interrupt, OR of the two status flags |

## Verification
The in-module assertions check, on every cycle, that a request is held until the sequencer finishes and that the fetch address does not move while a request is held. They also check that the tail moves only on a finish, that no fetch begins while the run bit is clear, and that the interrupt rises only after a finish and the error flag only with error reporting enabled. The bench's scenarios are needed for the rest: which addresses are fetched, and in what order, across a wrap in a shortened ring; the write-one-to-clear behaviour seen through the register port; and the run bit dropping in the middle of a fetch, followed by the ring staying idle.

// File: rtl/smb_ring_ctrl.sv
module smb_ring_ctrl #(
  parameter int PTR_W      = 8,
  parameter int ADDR_W     = 5,
  parameter int DESC_SHIFT = 4,
  parameter int DEF_LAST   = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              fetch_req,
  output logic [63:0]       fetch_addr,
  input  logic              seq_done,
  input  logic              seq_ok,
  input  logic              seq_irq,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFS_BASE_LO = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] OFS_BASE_HI = ADDR_W'(5'h04);
  localparam logic [ADDR_W-1:0] OFS_CTRL    = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] OFS_STAT    = ADDR_W'(5'h0C);
  localparam logic [ADDR_W-1:0] OFS_SIZE    = ADDR_W'(5'h10);
  localparam int PTR_LSB = 16;
  localparam int BIT_RUN = 0;
  localparam int BIT_ERR = 4;
  localparam int BIT_CMP = 5;

  logic [63:0]      base_q;
  logic             run_q, err_en_q;
  logic [PTR_W-1:0] head_q, tail_q, last_q;
  logic             busy_q, cmp_st_q, err_st_q;

  logic wr_lo, wr_hi, wr_ctrl, wr_stat, wr_size;
  assign wr_lo   = reg_wr && reg_addr == OFS_BASE_LO;
  assign wr_hi   = reg_wr && reg_addr == OFS_BASE_HI;
  assign wr_ctrl = reg_wr && reg_addr == OFS_CTRL;
  assign wr_stat = reg_wr && reg_addr == OFS_STAT;
  assign wr_size = reg_wr && reg_addr == OFS_SIZE;

  logic launch, finish;
  assign launch = !busy_q && run_q && (tail_q != head_q);
  assign finish = busy_q && seq_done;

  logic [PTR_W-1:0] tail_nx;
  assign tail_nx = (tail_q >= last_q) ? '0 : tail_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      run_q    <= 1'b0;
      err_en_q <= 1'b0;
      head_q   <= '0;
      last_q   <= PTR_W'(DEF_LAST);
      tail_q   <= '0;
      busy_q   <= 1'b0;
      cmp_st_q <= 1'b0;
      err_st_q <= 1'b0;
    end else begin
      if (wr_lo) base_q[31:0]  <= reg_wdata;
      if (wr_hi) base_q[63:32] <= reg_wdata;
      if (wr_ctrl) begin
        run_q    <= reg_wdata[BIT_RUN];
        err_en_q <= reg_wdata[BIT_ERR];
        head_q   <= reg_wdata[PTR_LSB +: PTR_W];
      end
      if (wr_size) last_q <= reg_wdata[PTR_W-1:0];
      if (launch)      busy_q <= 1'b1;
      else if (finish) busy_q <= 1'b0;
      if (finish) tail_q <= tail_nx;
      cmp_st_q <= (cmp_st_q & ~(wr_stat & reg_wdata[BIT_CMP])) | (finish & seq_irq);
      err_st_q <= (err_st_q & ~(wr_stat & reg_wdata[BIT_ERR])) | (finish & ~seq_ok & err_en_q);
    end
  end

  assign fetch_req  = busy_q;
  assign fetch_addr = base_q + ({{(64-PTR_W){1'b0}}, tail_q} << DESC_SHIFT);
  assign irq        = cmp_st_q | err_st_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_BASE_LO: reg_rdata = base_q[31:0];
      OFS_BASE_HI: reg_rdata = base_q[63:32];
      OFS_CTRL: begin
        reg_rdata[BIT_RUN]          = run_q;
        reg_rdata[BIT_ERR]          = err_en_q;
        reg_rdata[PTR_LSB +: PTR_W] = head_q;
      end
      OFS_STAT: begin
        reg_rdata[BIT_RUN]          = busy_q;
        reg_rdata[BIT_ERR]          = err_st_q;
        reg_rdata[BIT_CMP]          = cmp_st_q;
        reg_rdata[PTR_LSB +: PTR_W] = tail_q;
      end
      OFS_SIZE: reg_rdata[PTR_W-1:0] = last_q;
      default: reg_rdata = '0;
    endcase
  end

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !seq_done |=> fetch_req);

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req && !seq_done && !reg_wr |=> $stable(fetch_addr));

  assert_tail_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_req && seq_done) |=> $stable(tail_q));

  assert_no_fetch_halted_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q && !fetch_req |=> !fetch_req);

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(fetch_req && seq_done));

  assert_err_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_st_q) |-> $past(err_en_q));
endmodule

// File: tb/test_smb_ring_ctrl.sv
module test_smb_ring_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        fetch_req;
  logic [63:0] fetch_addr;
  logic        seq_done = 1'b0;
  logic        seq_ok = 1'b1;
  logic        seq_irq = 1'b0;
  logic        irq;

  always #4 clk = ~clk;

  smb_ring_ctrl i_smb_ring_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .seq_done(seq_done), .seq_ok(seq_ok),
    .seq_irq(seq_irq), .irq(irq)
  );

  int compared = 0;
  int mismatched = 0;
  logic [63:0] exp_q[$];
  logic cfg_ok = 1'b1;
  logic cfg_irq = 1'b0;
  logic stall = 1'b0;
  int spur_req = 0;
  int spur_ack = 0;
  logic [63:0] base = 64'h0000_0002_1000_0000;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(logic run, logic een, logic [7:0] head);
    return {8'h00, head, 11'h0, een, 3'h0, run};
  endfunction

  task automatic push(logic [7:0] slot);
    exp_q.push_back(base + {52'h0, slot, 4'h0});
  endtask

  task automatic wait_tail(logic [7:0] t, string req);
    logic [31:0] s;
    bit hit = 0;
    for (int n = 0; n < 400; n++) begin
      rd(5'h0C, s);
      if (s[23:16] == t && !s[0]) begin hit = 1; break; end
    end
    check(req, {56'h0, s[23:16]}, {56'h0, t});
  endtask

  // monitor and sequencer model: compares every fetch against the queue
  initial begin
    forever begin
      @(negedge clk);
      if (fetch_req) begin
        compared++;
        if (exp_q.size() == 0) begin
          mismatched++;
          $display("FAIL R3: actual fetch 0x%0h expected none", fetch_addr);
        end else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          if (fetch_addr !== e) begin
            mismatched++;
            $display("FAIL R2: actual 0x%0h expected 0x%0h", fetch_addr, e);
          end
        end
        while (stall) @(negedge clk);
        repeat (2) @(negedge clk);
        seq_done = 1'b1; seq_ok = cfg_ok; seq_irq = cfg_irq;
        @(negedge clk);
        seq_done = 1'b0;
      end else if (spur_req != spur_ack) begin
        seq_done = 1'b1; seq_ok = 1'b0; seq_irq = 1'b1;
        @(negedge clk);
        seq_done = 1'b0;
        spur_ack++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(5'h08, d); check("R1 ctrl", 64'(d), 0);
    rd(5'h0C, d); check("R1 stat", 64'(d), 0);
    rd(5'h10, d); check("R1 size", 64'(d), 31);
    rd(5'h00, d); check("R1 base", 64'(d), 0);
    check("R1 irq", 64'(irq), 0);
    check("R1 fetch_req", 64'(fetch_req), 0);

    // R2 base address
    wr(5'h00, base[31:0]);
    wr(5'h04, base[63:32]);
    rd(5'h00, d); check("R2 base lo", 64'(d), 64'(base[31:0]));
    rd(5'h04, d); check("R2 base hi", 64'(d), 64'(base[63:32]));

    // R3 R4 three descriptors, no interrupt request
    push(0); push(1); push(2);
    wr(5'h08, ctrl_word(1, 1, 8'd3));
    wait_tail(8'd3, "R4 tail after three");
    check("R6 no completion flag", 64'(irq), 0);
    repeat (10) @(negedge clk);
    check("R5 idle when tail==head", 64'(fetch_req), 0);

    // R6 R9 completion flag and interrupt
    cfg_irq = 1'b1;
    push(3);
    wr(5'h08, ctrl_word(1, 1, 8'd4));
    wait_tail(8'd4, "R4 tail 4");
    rd(5'h0C, d); check("R6 completion bit5", 64'(d[5]), 1);
    check("R9 irq high", 64'(irq), 1);
    wr(5'h0C, 32'h0);
    rd(5'h0C, d); check("R8 zero write keeps bit5", 64'(d[5]), 1);
    wr(5'h0C, 32'h20);
    rd(5'h0C, d); check("R8 one clears bit5", 64'(d[5]), 0);
    check("R9 irq low", 64'(irq), 0);

    // R7 error with and without enable
    cfg_irq = 1'b0; cfg_ok = 1'b0;
    push(4);
    wr(5'h08, ctrl_word(1, 1, 8'd5));
    wait_tail(8'd5, "R4 tail 5");
    rd(5'h0C, d); check("R7 error bit4", 64'(d[4]), 1);
    check("R9 irq on error", 64'(irq), 1);
    wr(5'h0C, 32'h10);
    rd(5'h0C, d); check("R8 one clears bit4", 64'(d[4]), 0);
    push(5);
    wr(5'h08, ctrl_word(1, 0, 8'd6));
    wait_tail(8'd6, "R4 tail 6");
    rd(5'h0C, d); check("R7 no error when disabled", 64'(d[4]), 0);

    // R11 shortened ring wraps after slot 7
    cfg_ok = 1'b1;
    wr(5'h10, 32'd7);
    push(6); push(7); push(0); push(1);
    wr(5'h08, ctrl_word(1, 1, 8'd2));
    wait_tail(8'd2, "R11 wrap to 2");

    // R5 clear run bit during a fetch
    stall = 1'b1;
    push(2);
    wr(5'h08, ctrl_word(1, 1, 8'd5));
    while (!fetch_req) @(negedge clk);
    rd(5'h0C, d); check("R3 in-progress bit0", 64'(d[0]), 1);
    wr(5'h08, ctrl_word(0, 1, 8'd5));
    check("R3 request held", 64'(fetch_req), 1);
    stall = 1'b0;
    repeat (20) @(negedge clk);
    rd(5'h0C, d);
    check("R5 tail after stop", 64'(d[23:16]), 3);
    check("R5 stopped", 64'(fetch_req), 0);

    // R10 done while idle
    spur_req++;
    repeat (6) @(negedge clk);
    rd(5'h0C, d);
    check("R10 tail unchanged", 64'(d[23:16]), 3);
    check("R10 flags unchanged", 64'(d[5:4]), 0);
    check("R2 all fetches seen", 64'(exp_q.size()), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule